// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block sends audio as the bus master on a single serial lane. It divides the system clock down to a bit clock and produces a frame sync or word-select line along with it. It shifts out parallel samples MSB first. A whole frame of samples enters through a valid/ready handshake and waits in a one-entry holding register. At each frame boundary the transmitter takes that frame and plays it out.

One shift path covers every framing style. There are three stereo styles: standard word-select, left-aligned and right-aligned. There are four pulse-sync variants, which differ only in where the sync pulse falls relative to the first data bit. There are five multi-slot framings with different sync-to-data offsets, and one of them moves the sync by half a bit clock. Each slot is 32 bit clocks wide. The sample length can be set from 16 to 32 bits.

The format and the sample length are read only at a frame boundary, so a frame is never played with mixed settings. If no frame is waiting at a boundary, the block sends a frame of zeros and raises an underrun flag for that frame.

Top module: `sat_tx`

## Requirements
- R1: While reset is held, bclk, fsync, sdo and underrun are low and s_ready is high.
- R2: bclk is high for CLK_DIV clock cycles, then low for CLK_DIV cycles. sdo and underrun change only in the cycle where bclk falls. fsync changes only where bclk changes level.
- R3: With cfg_fmt = 0 (standard word-select), a frame is 64 bit clocks. fsync is low while slot 0 (left) is sent and high while slot 1 (right) is sent. fsync changes one bit clock before the MSB of each slot.
- R4: With cfg_fmt = 1 (left-aligned), the MSB of each slot comes in the first bit clock after the fsync level change. With cfg_fmt = 2 (right-aligned), the LSB is the 32nd bit of the slot. In both, fsync is low for slot 0 and high for slot 1.
- R5: With cfg_fmt = 4, 5, 6 or 7, the frame is 64 bit clocks with slot 0 then slot 1. A one-bit-clock fsync pulse starts 1 bit clock before the MSB of slot 0 for code 4. It coincides with that MSB for code 5. It starts 1 bit clock after the MSB for code 6 and 2 bit clocks after for code 7.
- R6: With cfg_fmt = 8, 10, 11 or 12, the frame is SLOTS×32 bit clocks and the slots are sent in order. The one-bit-clock fsync pulse starts 0, 1 or 2 bit clocks after the MSB of slot 0 for codes 8, 10 and 11. For code 12 it starts one bit clock before that MSB.
- R7: With cfg_fmt = 9, the framing is multi-slot. fsync rises on the rising bclk edge inside the first bit of the frame and falls on the next rising edge.
- R8: The sample length is cfg_wl, clamped to 16 when below and to 32 when above. In every format except right-aligned, the sample starts at the slot's first bit. Bits of the slot not carrying the sample are driven low. The sample is taken from the low cfg_wl bits of its 32-bit lane: lane k is s_data[32k+31:32k], slot 0 is lane 0, and the sample's MSB is lane bit cfg_wl-1.
- R9: s_ready is high exactly when the holding register is empty. An accepted frame is played starting at the next frame boundary.
- R10: If the holding register is empty at a frame boundary, the whole next frame is zeros and underrun is high for exactly that frame.
- R11: cfg_fmt and cfg_wl are sampled only at frame boundaries. Codes 3, 13, 14 and 15 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 4 | Framing format code, sampled at frame boundary |
| cfg_wl | input | 6 | Sample length in bits, sampled at frame boundary |
| s_valid | input | 1 | Frame of samples offered |
| s_data | input | SLOTS×32 | One 32-bit lane per slot, sample in the low bits |
| s_ready | output | 1 | Holding register empty |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Word-select level or frame sync pulse |
| sdo | output | 1 | Serial data, changes on falling bclk |
| underrun | output | 1 | High during a zero-filled frame |

## Verification
The bench builds the block with CLK_DIV = 2 and SLOTS = 4. A two-cycle half period keeps each bit clock short, so every format code, including the four-slot framings, can run several frames within a modest cycle count. Four slots make the multi-slot frame (128 bit clocks) differ in length from the stereo frame (64), so switching between them at a boundary tests the frame-length choice. Sample lengths of 16, 18, 20, 24 and 32 are used, plus clamped values of 8 and 40. An idle gap produces underrun frames, and unused format codes are also sent.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [3:0] {
        FMT_I2S      = 4'd0,
        FMT_LJ       = 4'd1,
        FMT_RJ       = 4'd2,
        FMT_PCM_E    = 4'd4,
        FMT_PCM_L1   = 4'd5,
        FMT_PCM_L2   = 4'd6,
        FMT_PCM_L3   = 4'd7,
        FMT_TDM      = 4'd8,
        FMT_TDM_HALF = 4'd9,
        FMT_TDM_L1   = 4'd10,
        FMT_TDM_L2   = 4'd11,
        FMT_TDM_R    = 4'd12
    } fmt_e;

    // Unused codes fall back to the standard word-select format
    function automatic fmt_e decode_fmt(input logic [3:0] code);
        case (code)
            4'd3, 4'd13, 4'd14, 4'd15: return FMT_I2S;
            default:                   return fmt_e'(code);
        endcase
    endfunction

    function automatic logic [5:0] clamp_wl(input logic [5:0] w);
        if (w < 6'd16) return 6'd16;
        if (w > 6'd32) return 6'd32;
        return w;
    endfunction

    function automatic logic is_tdm(input fmt_e f);
        return f inside {FMT_TDM, FMT_TDM_HALF, FMT_TDM_L1, FMT_TDM_L2, FMT_TDM_R};
    endfunction

endpackage

// File: rtl/sat_bclk_gen.sv
module sat_bclk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick;

    always_comb begin
        gen_d = gen_q;
        tick  = (gen_q.cnt == CW'(CLK_DIV - 1));
        if (tick) begin
            gen_d.cnt  = '0;
            gen_d.bclk = ~gen_q.bclk;
        end else begin
            gen_d.cnt  = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign bclk     = gen_q.bclk;
    assign rise_evt = tick & ~gen_q.bclk;
    assign fall_evt = tick &  gen_q.bclk;
endmodule

// File: rtl/sat_sample_slot.sv
module sat_sample_slot #(
    parameter int FW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [FW-1:0] in_data,
    output logic          in_ready,
    input  logic          consume,
    output logic          full,
    output logic [FW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [FW-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  take;

    always_comb begin
        slot_d = slot_q;
        take   = in_valid & ~slot_q.full;
        if (consume) slot_d.full = 1'b0;
        if (take) begin
            slot_d.full = 1'b1;
            slot_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign in_ready = ~slot_q.full;
    assign full     = slot_q.full;
    assign data     = slot_q.data;
endmodule

// File: rtl/sat_frame_map.sv
module sat_frame_map
    import sat_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  fmt_e                             fmt,
    input  logic [5:0]                       wl,
    input  logic [$clog2(SLOTS*32)-1:0]      pos,
    input  logic [SLOTS*32-1:0]              frame,
    output logic                             bit_o,
    output logic                             sync_o
);
    localparam int FW = SLOTS * 32;
    localparam int PW = $clog2(FW);

    logic [31:0]   word;
    logic [4:0]    j;
    logic [5:0]    jx;
    logic [4:0]    sel;
    logic          inside_w;
    logic [PW-1:0] p1;
    logic [PW-1:0] frame_last;

    always_comb begin
        word = frame[{pos[PW-1:5], 5'b0} +: 32];
        j    = pos[4:0];
        jx   = {1'b0, j};
        if (fmt == FMT_RJ) begin
            inside_w = (jx >= (6'd32 - wl));
            sel      = 5'(6'd31 - jx);
        end else begin
            inside_w = (jx < wl);
            sel      = 5'(wl - 6'd1 - jx);
        end
        bit_o = inside_w & word[sel];

        p1         = pos + 1'b1;
        frame_last = is_tdm(fmt) ? PW'(FW - 1) : PW'(63);
        case (fmt)
            FMT_LJ, FMT_RJ:         sync_o = pos[5];
            FMT_PCM_E, FMT_TDM_R:   sync_o = (pos == frame_last);
            FMT_PCM_L1, FMT_TDM:    sync_o = (pos == PW'(0));
            FMT_PCM_L2, FMT_TDM_L1,
            FMT_TDM_HALF:           sync_o = (pos == PW'(1));
            FMT_PCM_L3, FMT_TDM_L2: sync_o = (pos == PW'(2));
            default:                sync_o = p1[5];
        endcase
    end
endmodule

// File: rtl/sat_tx.sv
module sat_tx
    import sat_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int SLOTS   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            cfg_fmt,
    input  logic [5:0]            cfg_wl,
    input  logic                  s_valid,
    input  logic [SLOTS*32-1:0]   s_data,
    output logic                  s_ready,
    output logic                  bclk,
    output logic                  fsync,
    output logic                  sdo,
    output logic                  underrun
);
    localparam int FW = SLOTS * 32;
    localparam int PW = $clog2(FW);

    typedef struct packed {
        logic [PW-1:0] pos;
        fmt_e          mode;
        logic [5:0]    wl;
        logic [FW-1:0] frame;
        logic          sdo;
        logic          fsync;
        logic          underrun;
    } tx_t;

    tx_t tx_d, tx_q;

    logic          rise_evt, fall_evt;
    logic          slot_full;
    logic [FW-1:0] slot_data;
    logic          boundary;
    logic [PW-1:0] last_pos;
    logic [PW-1:0] pos_nx;
    fmt_e          mode_nx;
    logic [5:0]    wl_nx;
    logic [FW-1:0] frame_nx;
    logic          und_nx;
    logic          map_bit, map_sync;

    sat_bclk_gen #(.CLK_DIV(CLK_DIV)) u_gen (
        .clk(clk), .rst_n(rst_n), .bclk(bclk),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    sat_sample_slot #(.FW(FW)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s_valid), .in_data(s_data), .in_ready(s_ready),
        .consume(boundary), .full(slot_full), .data(slot_data)
    );

    // Next frame position and frame-level settings
    always_comb begin
        last_pos = is_tdm(tx_q.mode) ? PW'(FW - 1) : PW'(63);
        boundary = fall_evt & (tx_q.pos == last_pos);
        pos_nx   = tx_q.pos + 1'b1;
        mode_nx  = tx_q.mode;
        wl_nx    = tx_q.wl;
        frame_nx = tx_q.frame;
        und_nx   = tx_q.underrun;
        if (boundary) begin
            pos_nx   = '0;
            mode_nx  = decode_fmt(cfg_fmt);
            wl_nx    = clamp_wl(cfg_wl);
            frame_nx = slot_full ? slot_data : '0;
            und_nx   = ~slot_full;
        end
    end

    sat_frame_map #(.SLOTS(SLOTS)) u_map (
        .fmt(mode_nx), .wl(wl_nx), .pos(pos_nx), .frame(frame_nx),
        .bit_o(map_bit), .sync_o(map_sync)
    );

    always_comb begin
        tx_d = tx_q;
        if (fall_evt) begin
            tx_d.pos      = pos_nx;
            tx_d.mode     = mode_nx;
            tx_d.wl       = wl_nx;
            tx_d.frame    = frame_nx;
            tx_d.underrun = und_nx;
            tx_d.sdo      = map_bit;
            tx_d.fsync    = map_sync;
        end else if (rise_evt && tx_q.mode == FMT_TDM_HALF) begin
            tx_d.fsync    = (tx_q.pos == PW'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q          <= '0;
            tx_q.pos      <= PW'(63);
            tx_q.mode     <= FMT_I2S;
            tx_q.wl       <= 6'd32;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sdo      = tx_q.sdo;
    assign fsync    = tx_q.fsync;
    assign underrun = tx_q.underrun;
endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic s_valid,
    input logic s_ready,
    input logic bclk,
    input logic fsync,
    input logic sdo,
    input logic underrun
);
    logic [15:0] gap_q;
    logic        bclk_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= '0;
            bclk_last_q <= 1'b0;
        end else begin
            bclk_last_q <= bclk;
            if (bclk != bclk_last_q) gap_q <= 16'd1;
            else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
        end
    end

    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk != bclk_last_q) |-> (gap_q == 16'(CLK_DIV)));

    a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $fell(bclk));

    a_r2_fsync_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsync) |-> !$stable(bclk));

    a_r10_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(underrun) |-> $fell(bclk));

    a_r10_underrun_silent: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !sdo);

    a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);
endmodule

bind sat_tx sat_tx_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .bclk(bclk), .fsync(fsync), .sdo(sdo), .underrun(underrun)
);

// File: tb/test_sat_tx.sv
module test_sat_tx;
    localparam int CLK_DIV = 2;
    localparam int SLOTS   = 4;
    localparam int FW      = SLOTS * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_fmt = 4'd0;
    logic [5:0]    cfg_wl = 6'd24;
    logic          s_valid = 1'b0;
    logic [FW-1:0] s_data = '0;
    logic          s_ready, bclk, fsync, sdo, underrun;

    sat_tx #(.CLK_DIV(CLK_DIV), .SLOTS(SLOTS)) i_sat_tx (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wl(cfg_wl),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .bclk(bclk), .fsync(fsync), .sdo(sdo), .underrun(underrun)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string tag    = "R3";

    // Reference model state
    int            m_hc, m_pos, m_mode, m_wl;
    bit            m_bclk, m_fs, m_sdo, m_und;
    logic [31:0]   m_fr [SLOTS];
    logic [FW-1:0] m_q [$];
    // Inputs seen before the last rising clock edge
    bit            l_rst = 0, l_valid = 0, l_ready = 0;
    logic [FW-1:0] l_data = '0;
    int            l_fmt = 0, l_wl = 24;

    function automatic int norm_fmt(int c);
        if (c == 3 || c > 12) return 0;
        return c;
    endfunction

    function automatic int lim_wl(int w);
        if (w < 16) return 16;
        if (w > 32) return 32;
        return w;
    endfunction

    function automatic int frame_len(int md);
        return (md >= 8) ? SLOTS * 32 : 64;
    endfunction

    function automatic bit exp_bit(int p);
        int s = p / 32;
        int j = p % 32;
        int first = (m_mode == 2) ? 32 - m_wl : 0;
        if (j >= first && j < first + m_wl) return m_fr[s][m_wl - 1 - (j - first)];
        return 1'b0;
    endfunction

    function automatic bit exp_sync(int p);
        case (m_mode)
            0:     return ((p + 1) % 64) >= 32;
            1, 2:  return p >= 32;
            4:     return p == 63;
            5, 8:  return p == 0;
            6, 9, 10: return p == 1;
            7, 11: return p == 2;
            12:    return p == frame_len(12) - 1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_hc = 0; m_bclk = 0; m_pos = 63; m_mode = 0; m_wl = 32;
        m_fs = 0; m_sdo = 0; m_und = 0;
        for (int s = 0; s < SLOTS; s++) m_fr[s] = '0;
        m_q.delete();
    endtask

    task automatic model_edge();
        m_hc++;
        if (m_hc == CLK_DIV) begin
            m_hc = 0;
            m_bclk = !m_bclk;
            if (m_bclk) begin
                if (m_mode == 9) m_fs = (m_pos == 0);
            end else begin
                if (m_pos == frame_len(m_mode) - 1) begin
                    m_pos  = 0;
                    m_mode = norm_fmt(l_fmt);
                    m_wl   = lim_wl(l_wl);
                    if (m_q.size() > 0) begin
                        logic [FW-1:0] f = m_q.pop_front();
                        for (int s = 0; s < SLOTS; s++) m_fr[s] = f[s*32 +: 32];
                        m_und = 0;
                    end else begin
                        for (int s = 0; s < SLOTS; s++) m_fr[s] = '0;
                        m_und = 1;
                    end
                end else begin
                    m_pos++;
                end
                m_sdo = exp_bit(m_pos);
                m_fs  = exp_sync(m_pos);
            end
        end
        if (l_valid && l_ready) m_q.push_back(l_data);
    endtask

    task automatic chk(string req, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            if (fails <= 30)
                $display("FAIL %s %s at %0t: actual %0b expected %0b", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!l_rst) model_reset();
        else        model_edge();
        if (rst_n && l_rst) begin
            chk("R2", "bclk", bclk, m_bclk);
            chk(tag, "fsync", fsync, m_fs);
            chk(tag, "sdo", sdo, m_sdo);
            chk("R10", "underrun", underrun, m_und);
            chk("R9", "s_ready", s_ready, m_q.size() == 0);
        end
        l_rst   = rst_n;
        l_valid = s_valid;
        l_ready = s_ready;
        l_data  = s_data;
        l_fmt   = cfg_fmt;
        l_wl    = cfg_wl;
    end

    task automatic feed(int fmt, int wl, string t, int n);
        cfg_fmt = 4'(fmt);
        cfg_wl  = 6'(wl);
        tag     = t;
        for (int i = 0; i < n; i++) begin
            bit r;
            for (int s = 0; s < SLOTS; s++) s_data[s*32 +: 32] = $urandom;
            s_valid = 1'b1;
            r = 0;
            while (!r) begin
                r = s_ready;
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "bclk in reset", bclk, 1'b0);
        chk("R1", "fsync in reset", fsync, 1'b0);
        chk("R1", "sdo in reset", sdo, 1'b0);
        chk("R1", "underrun in reset", underrun, 1'b0);
        chk("R1", "s_ready in reset", s_ready, 1'b1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        feed(0, 24, "R3", 3);
        feed(0, 32, "R3", 3);
        feed(1, 20, "R4", 3);
        feed(2, 16, "R4", 3);
        feed(2, 24, "R4", 2);
        feed(4, 16, "R5", 3);
        feed(5, 24, "R5", 2);
        feed(6, 32, "R5", 2);
        feed(7, 18, "R5", 2);
        feed(8, 24, "R6", 2);
        feed(9, 16, "R7", 3);
        feed(10, 32, "R6", 2);
        feed(11, 20, "R6", 2);
        feed(12, 24, "R6", 2);
        feed(0, 8, "R8", 2);
        feed(1, 40, "R8", 2);
        feed(14, 24, "R11", 2);

        // R10: starve the holding register
        s_valid = 1'b0;
        tag = "R10";
        repeat (1200) @(posedge clk);
        @(negedge clk);
        chk("R10", "underrun after idle", underrun, 1'b1);
        chk("R10", "sdo during underrun", sdo, 1'b0);
        @(posedge clk); #1;

        feed(3, 16, "R11", 2);
        feed(9, 32, "R7", 2);
        s_valid = 1'b0;
        repeat (1500) @(posedge clk);
        @(negedge clk);
        chk("R10", "underrun after drain", underrun, 1'b1);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule